// File: doc/BRIEF.md
# Serial DAC Frame Loader

This block sits between a host parallel port and an octal DAC that takes its input serially. The host puts a data byte on its eight data lines and pulls the data strobe low. It then puts a channel number on the low four lines and pulls the address strobe low. Each value is held in its own capture register. Raising the start line then begins a transfer. The start line is asynchronous to the block's clock, so it passes through a two-stage synchronizer. Its rising level becomes a one-cycle, active-low start pulse.

The start pulse freezes both capture registers and builds a 16-bit frame: four zero pad bits, then the four channel bits (MSB first), then the data byte (MSB first). The frame counter is preset to 1 by the pulse. The first two frame bits move out before any serial clock edge is driven, so the DAC sees only the last two pad zeros. After that, each rising edge of the serial clock presents one bit and advances the counter. When the counter reaches its terminal count of 15 (after the 14th edge), the serial clock stops and the DAC load strobe is pulsed low for one cycle. The capture registers are then armed again for the next pair.

The serial clock is driven from a flop at half the system clock rate, so it cannot glitch. Serial data changes only while the serial clock is low.

Top module: `dac_frame_loader`

## Requirements
- R1: After reset, `sclk_o` and `sdata_o` are 0, `dac_load_no` is 1 and `busy_o` is 0.
- R2: While the block is idle and `data_stb_ni` is low, the byte on `host_data_i[7:0]` is captured, and it forms the last eight bits of the next frame.
- R3: While the block is idle and `addr_stb_ni` is low, the nibble `host_data_i[3:0]` is captured as a channel number 1..8. The channel number minus one (modulo 16) is sent as the four channel bits, MSB first. Out-of-range values are not checked.
- R4: A rising level on `start_i` that is driven half a cycle before a clock edge shows `busy_o` high after the third rising clock edge, and not after the second.
- R5: A transfer starts only on a rising level of `start_i`. Holding `start_i` high after a frame has ended does not start another frame.
- R6: The DAC sees exactly 14 bits per frame, sampled on the serial clock's rising edges: two zeros, the four channel bits, then data bits D7 down to D0.
- R7: `sclk_o` is never high for two consecutive cycles. `sdata_o` does not change in a cycle where `sclk_o` is high.
- R8: `dac_load_no` goes low for exactly one cycle per frame, after the 14th serial clock rise, and `sclk_o` is low during that cycle.
- R9: `busy_o` stays high from the cycle after the start pulse through the load strobe cycle, and falls in the cycle after it.
- R10: A rising level on `start_i` while `busy_o` is high is ignored: the frame is not restarted and no second frame follows.
- R11: Strobes received while `busy_o` is high do not change the captured values. The next frame sends the values captured before the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_data_i | input | 8 | Host data lines |
| data_stb_ni | input | 1 | Data byte strobe, active low |
| addr_stb_ni | input | 1 | Channel address strobe, active low |
| start_i | input | 1 | Asynchronous transfer trigger, acts on its rising level |
| sclk_o | output | 1 | Gated serial clock to the DAC |
| sdata_o | output | 1 | Serial data to the DAC |
| dac_load_no | output | 1 | DAC load strobe, active low |
| busy_o | output | 1 | High while a frame is in progress |

## Verification
The bench records every bit present on `sdata_o` at a rising edge of `sclk_o`. It compares that bit string with the expected 14-bit tail, for random channel numbers and data bytes and for extreme data values. A wrong counter preset or a wrong skip count would shift the tail by one bit or change the number of edges. A swapped order would reverse the channel bits.

Retriggering `start_i` in the middle of a frame checks that a design which rearms on every edge does not restart the frame or run a second one. Holding `start_i` high across the end of a frame checks that a design which acts on the level of the trigger does not loop. Pulsing the strobes during a frame checks that a design which leaves the capture registers open would leak the new values into the following frame.

The start latency is checked to the exact cycle. A synchronizer with one stage too few or one too many shows the busy flag one cycle early or one cycle late.

// File: rtl/dlf_pkg.sv
package dlf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SKIP,
    ST_LOW,
    ST_HIGH,
    ST_LOAD
  } seq_state_e;
endpackage

// File: rtl/dlf_start_sync.sv
module dlf_start_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic start_pulse_no
);
  logic [SYNC_STAGES:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[SYNC_STAGES-1:0], start_i};
  end

  // low for one cycle after a synchronized rising level
  assign start_pulse_no = ~(pipe_q[SYNC_STAGES-1] & ~pipe_q[SYNC_STAGES]);
endmodule

// File: rtl/dlf_capture.sv
module dlf_capture #(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 4,
  parameter bit ONE_BASED = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic [DATA_W-1:0] host_data_i,
  input  logic              data_stb_ni,
  input  logic              addr_stb_ni,
  output logic [DATA_W-1:0] data_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_code;

  generate
    if (ONE_BASED) begin : g_one_based
      assign addr_code = host_data_i[ADDR_W-1:0] - ADDR_W'(1);
    end else begin : g_zero_based
      assign addr_code = host_data_i[ADDR_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      addr_o <= '0;
    end else if (arm_i) begin
      if (!data_stb_ni) data_o <= host_data_i;
      if (!addr_stb_ni) addr_o <= addr_code;
    end
  end
endmodule

// File: rtl/dlf_serializer.sv
module dlf_serializer
  import dlf_pkg::*;
#(
  parameter int PAD_W    = 4,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8,
  parameter int CNT_INIT = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_pulse_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              sclk_o,
  output logic              sdata_o,
  output logic              load_no,
  output logic              busy_o,
  output logic              arm_o
);
  localparam int FRAME_W = PAD_W + ADDR_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam int TERM    = FRAME_W - 1;
  localparam int SKIP    = CNT_INIT + 1;
  localparam int SKIP_W  = $clog2(SKIP + 1);

  seq_state_e         state_q;
  logic [FRAME_W-1:0] sreg_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [SKIP_W-1:0]  skip_q;
  logic               sclk_q;
  logic               load_nq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sreg_q  <= '0;
      cnt_q   <= '0;
      skip_q  <= '0;
      sclk_q  <= 1'b0;
      load_nq <= 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (!start_pulse_ni) begin
            sreg_q  <= {{PAD_W{1'b0}}, addr_i, data_i};
            cnt_q   <= CNT_W'(CNT_INIT);
            skip_q  <= '0;
            state_q <= ST_SKIP;
          end
        end
        // leading bits leave before the serial clock runs
        ST_SKIP: begin
          sreg_q <= {sreg_q[FRAME_W-2:0], 1'b0};
          skip_q <= skip_q + SKIP_W'(1);
          if (skip_q == SKIP_W'(SKIP - 1)) state_q <= ST_LOW;
        end
        ST_LOW: begin
          sclk_q  <= 1'b1;
          cnt_q   <= cnt_q + CNT_W'(1);
          state_q <= ST_HIGH;
        end
        ST_HIGH: begin
          sclk_q <= 1'b0;
          if (cnt_q == CNT_W'(TERM)) begin
            load_nq <= 1'b0;
            state_q <= ST_LOAD;
          end else begin
            sreg_q  <= {sreg_q[FRAME_W-2:0], 1'b0};
            state_q <= ST_LOW;
          end
        end
        ST_LOAD: begin
          load_nq <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sclk_o  = sclk_q;
  assign sdata_o = sreg_q[FRAME_W-1];
  assign load_no = load_nq;
  assign busy_o  = (state_q != ST_IDLE);
  assign arm_o   = (state_q == ST_IDLE);
endmodule

// File: rtl/dac_frame_loader.sv
module dac_frame_loader #(
  parameter int PAD_W       = 4,
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int CNT_INIT    = 1,
  parameter int SYNC_STAGES = 2,
  parameter bit ONE_BASED   = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] host_data_i,
  input  logic              data_stb_ni,
  input  logic              addr_stb_ni,
  input  logic              start_i,
  output logic              sclk_o,
  output logic              sdata_o,
  output logic              dac_load_no,
  output logic              busy_o
);
  localparam int FRAME_W    = PAD_W + ADDR_W + DATA_W;
  localparam int RISE_TOTAL = FRAME_W - CNT_INIT - 1;

  logic              start_pulse_n;
  logic              arm;
  logic [DATA_W-1:0] data_q;
  logic [ADDR_W-1:0] addr_q;

  dlf_start_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start_i),
    .start_pulse_no(start_pulse_n)
  );

  dlf_capture #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .ONE_BASED(ONE_BASED)) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .arm_i      (arm),
    .host_data_i(host_data_i),
    .data_stb_ni(data_stb_ni),
    .addr_stb_ni(addr_stb_ni),
    .data_o     (data_q),
    .addr_o     (addr_q)
  );

  dlf_serializer #(
    .PAD_W(PAD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_INIT(CNT_INIT)
  ) u_ser (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_pulse_ni(start_pulse_n),
    .addr_i        (addr_q),
    .data_i        (data_q),
    .sclk_o        (sclk_o),
    .sdata_o       (sdata_o),
    .load_no       (dac_load_no),
    .busy_o        (busy_o),
    .arm_o         (arm)
  );
endmodule

// File: rtl/dlf_checker.sv
module dlf_checker #(
  parameter int RISE_TOTAL = 14
) (
  input logic clk_i,
  input logic rst_ni,
  input logic sclk_o,
  input logic sdata_o,
  input logic dac_load_no,
  input logic busy_o
);
  localparam int RC_W = $clog2(RISE_TOTAL + 1) + 1;

  logic            sclk_d;
  logic [RC_W-1:0] rise_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d   <= 1'b0;
      rise_cnt <= '0;
    end else begin
      sclk_d <= sclk_o;
      if (!busy_o)                rise_cnt <= '0;
      else if (sclk_o && !sclk_d) rise_cnt <= rise_cnt + RC_W'(1);
    end
  end

  a_r7_sclk_single_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |=> !sclk_o);
  a_r7_data_stable_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> $stable(sdata_o));
  a_r8_load_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dac_load_no |=> dac_load_no);
  a_r8_sclk_low_at_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dac_load_no |-> !sclk_o);
  a_r8_rise_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dac_load_no |-> (rise_cnt == RC_W'(RISE_TOTAL)));
  a_r9_busy_at_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dac_load_no |-> busy_o);
  a_r9_busy_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dac_load_no |=> !busy_o);
  a_r9_sclk_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> busy_o);
endmodule

bind dac_frame_loader dlf_checker #(.RISE_TOTAL(RISE_TOTAL)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sclk_o     (sclk_o),
  .sdata_o    (sdata_o),
  .dac_load_no(dac_load_no),
  .busy_o     (busy_o)
);

// File: tb/dac_frame_loader_bench.sv
module dac_frame_loader_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] host_data_i = 8'h00;
  logic       data_stb_ni = 1'b1;
  logic       addr_stb_ni = 1'b1;
  logic       start_i = 1'b0;
  logic       sclk_o, sdata_o, dac_load_no, busy_o;

  int checks = 0;
  int failures = 0;

  always #10 clk_i = ~clk_i;

  dac_frame_loader u_dac_frame_loader (
    .clk_i(clk_i), .rst_ni(rst_ni), .host_data_i(host_data_i),
    .data_stb_ni(data_stb_ni), .addr_stb_ni(addr_stb_ni), .start_i(start_i),
    .sclk_o(sclk_o), .sdata_o(sdata_o), .dac_load_no(dac_load_no), .busy_o(busy_o)
  );

  // port monitor, mid-cycle
  logic        prev_sclk = 1'b0;
  logic        prev_busy = 1'b0;
  logic [31:0] got_bits = '0;
  int          rises = 0, loads = 0, load_sclk_hi = 0, load_not_busy = 0, busy_rises = 0;

  always @(negedge clk_i) begin
    if (sclk_o && !prev_sclk) begin
      got_bits = {got_bits[30:0], sdata_o};
      rises++;
    end
    if (!dac_load_no) begin
      loads++;
      if (sclk_o) load_sclk_hi++;
      if (!busy_o) load_not_busy++;
    end
    if (busy_o && !prev_busy) busy_rises++;
    prev_sclk = sclk_o;
    prev_busy = busy_o;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [13:0] exp_bits(input logic [3:0] ch, input logic [7:0] d);
    return {2'b00, ch - 4'd1, d};
  endfunction

  task automatic load_host(input logic [3:0] ch, input logic [7:0] d);
    @(negedge clk_i); host_data_i = d;  data_stb_ni = 1'b0;
    @(negedge clk_i); data_stb_ni = 1'b1; host_data_i = {4'h0, ch}; addr_stb_ni = 1'b0;
    @(negedge clk_i); addr_stb_ni = 1'b1; host_data_i = 8'($urandom);
  endtask

  // raise start, wait for the load strobe and idle; optional retrigger / strobe noise
  task automatic fire(input bit retrig, input bit noise);
    int l0 = loads;
    @(negedge clk_i); start_i = 1'b1;
    for (int i = 0; i < 200 && !busy_o; i++) @(negedge clk_i);
    if (retrig || noise) begin
      repeat (6) @(negedge clk_i);
      if (retrig) start_i = 1'b0;
      if (noise) begin host_data_i = 8'h5A; data_stb_ni = 1'b0; end
      @(negedge clk_i);
      if (noise) begin data_stb_ni = 1'b1; host_data_i = 8'h03; addr_stb_ni = 1'b0; end
      @(negedge clk_i);
      if (retrig) start_i = 1'b1;
      addr_stb_ni = 1'b1;
    end
    for (int i = 0; i < 200 && !(loads > l0 && !busy_o); i++) @(negedge clk_i);
  endtask

  task automatic frame_checks(input logic [3:0] ch, input logic [7:0] d, input int r0, input int l0);
    logic [13:0] e = exp_bits(ch, d);
    check(rises - r0 == 14, "R6 rise count", rises - r0, 14);
    check(got_bits[7:0] == d, "R2 data bits", int'(got_bits[7:0]), int'(d));
    check(got_bits[11:8] == e[11:8], "R3 channel bits", int'(got_bits[11:8]), int'(e[11:8]));
    check(got_bits[13:0] == e, "R6 frame", int'(got_bits[13:0]), int'(e));
    check(loads - l0 == 1, "R8 load width", loads - l0, 1);
    check(!busy_o, "R9 busy low after load", int'(busy_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int r0, l0, b0;
    logic [3:0] ch;
    logic [7:0] d;
    void'($urandom(32'd20250));
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check(!sclk_o && !sdata_o && dac_load_no && !busy_o, "R1 reset outputs",
          {sclk_o, sdata_o, dac_load_no, busy_o}, 4'b0010);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // R4 exact latency
    load_host(4'd3, 8'hC4);
    r0 = rises; l0 = loads;
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); @(negedge clk_i);
    check(!busy_o, "R4 busy not after 2 edges", int'(busy_o), 0);
    @(negedge clk_i);
    check(busy_o, "R4 busy after 3 edges", int'(busy_o), 1);
    for (int i = 0; i < 200 && !(loads > l0 && !busy_o); i++) @(negedge clk_i);
    frame_checks(4'd3, 8'hC4, r0, l0);

    // R5 level held: no restart
    b0 = busy_rises;
    repeat (20) @(negedge clk_i);
    check(busy_rises == b0, "R5 held start no restart", busy_rises - b0, 0);
    start_i = 1'b0;
    repeat (4) @(negedge clk_i);

    // directed corners
    for (int k = 0; k < 4; k++) begin
      ch = (k < 2) ? 4'd1 : 4'd8;
      d  = k[0] ? 8'hFF : 8'h00;
      load_host(ch, d);
      r0 = rises; l0 = loads;
      fire(1'b0, 1'b0);
      frame_checks(ch, d, r0, l0);
      start_i = 1'b0; repeat (4) @(negedge clk_i);
    end

    // R3 out-of-range value 0 wraps to code 15
    load_host(4'd0, 8'h81);
    r0 = rises; l0 = loads;
    fire(1'b0, 1'b0);
    check(got_bits[11:8] == 4'hF, "R3 unchecked wrap", int'(got_bits[11:8]), 15);
    start_i = 1'b0; repeat (4) @(negedge clk_i);

    // R10 retrigger ignored, R11 strobes ignored while busy
    load_host(4'd6, 8'h2D);
    r0 = rises; l0 = loads; b0 = busy_rises;
    fire(1'b1, 1'b1);
    repeat (20) @(negedge clk_i);
    check(busy_rises - b0 == 1, "R10 no second frame", busy_rises - b0, 1);
    check(loads - l0 == 1, "R10 single load", loads - l0, 1);
    check(rises - r0 == 14, "R10 no restart", rises - r0, 14);
    check(got_bits[13:0] == exp_bits(4'd6, 8'h2D), "R10 frame intact",
          int'(got_bits[13:0]), int'(exp_bits(4'd6, 8'h2D)));
    start_i = 1'b0; repeat (4) @(negedge clk_i);
    r0 = rises; l0 = loads;
    fire(1'b0, 1'b0);
    check(got_bits[13:0] == exp_bits(4'd6, 8'h2D), "R11 capture frozen",
          int'(got_bits[13:0]), int'(exp_bits(4'd6, 8'h2D)));
    start_i = 1'b0; repeat (4) @(negedge clk_i);

    // random frames
    for (int k = 0; k < 24; k++) begin
      ch = 4'($urandom_range(8, 1));
      d  = 8'($urandom);
      load_host(ch, d);
      r0 = rises; l0 = loads;
      fire(1'b0, 1'b0);
      frame_checks(ch, d, r0, l0);
      start_i = 1'b0;
      repeat (2 + $urandom_range(5)) @(negedge clk_i);
    end

    // R8 sclk low during load, R9 busy through load
    check(load_sclk_hi == 0, "R8 sclk low at load", load_sclk_hi, 0);
    check(load_not_busy == 0, "R9 busy at load", load_not_busy, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule